// File: doc/BRIEF.md
# DRAM Bank State Timing Checker

This block watches the command bus between a memory controller and a DDR2-style DRAM and judges every command the DRAM would register. It decodes chip select and the three row/column/write strobes, along with the bank address and address bit 10. It keeps a row state per bank (idle, open, or open with an automatic precharge pending) and per-bank interval counters. Each command is checked against the minimum activate-to-column, precharge period, row-active and row-cycle intervals. Those intervals are given in picoseconds and turned into whole clock cycles by rounding up against the clock period parameter.

A command that breaks a rule gets a one-cycle violation pulse with a 3-bit code, and it is discarded: the tracked bank state behaves as if the command had never been issued. A status vector shows which banks currently hold an open row. The block only observes. It has no data path and drives nothing back onto the bus. All its pins are plain control and status pins, so no valid/ready handshake or back-pressure applies.

Top module: `dram_bank_timing_checker`

## Requirements
- R1: After reset all banks are idle, `bank_open` is 0, `viol` is 0 and `viol_code` is 0. The interval counters start saturated, so the first activate to any bank is legal.
- R2: A cycle with `cs_n` high is treated as no command whatever the strobes carry: it raises no violation and changes no bank state.
- R3: With `cs_n` low, the strobes decode as (ras_n, cas_n, we_n): 011 activate, 101 read, 100 write, 010 precharge, 111 no operation. An activate to an idle bank sets that bank's `bank_open` bit one cycle later. An activate to a bank whose row is open gives code 1.
- R4: A read or write to a bank that has no open row gives code 2. This includes a bank that is waiting for its automatic precharge.
- R5: A read or write issued fewer than tRCD cycles after that bank's activate gives code 5.
- R6: An activate issued fewer than tRP cycles after that bank's precharge began gives code 3. An activate to a bank waiting for its automatic precharge also gives code 3.
- R7: An activate that passes the tRP rule but comes fewer than tRC cycles after that bank's previous accepted activate gives code 4.
- R8: A precharge with `addr10` low acts only on the bank `ba` selects. On an open bank it gives code 6 if fewer than tRAS cycles have passed since the activate; otherwise it closes the bank and starts tRP. On an idle bank it is legal and has no effect.
- R9: A precharge with `addr10` high acts on all open banks. If any of them is younger than tRAS it gives code 6 and no bank closes; otherwise every open bank closes.
- R10: A read or write with `addr10` high leaves the row open and requests an automatic precharge. The internal precharge happens at the later of two edges: the command edge plus BURST_CYC, and the activate edge plus tRAS. At that edge the bank becomes idle and tRP starts.
- R11: Any other encoding with `cs_n` low (ras_n and cas_n both low, or strobes 110) gives code 7 and has no effect.
- R12: Violations are registered. `viol` is high, with `viol_code` non-zero, in exactly the cycle after the offending command's edge. Otherwise both are 0, and the offending command changes no state.
- R13: Each interval in cycles is the interval in picoseconds divided by CLK_PS, rounded up. The defaults (15000, 15000, 45000, 60000 at 5000 ps) give 3, 3, 9 and 12 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BA_W | Bank address |
| addr10 | input | 1 | Address bit 10: auto-precharge on column commands, all-bank on precharge |
| viol | output | 1 | One-cycle violation pulse |
| viol_code | output | 3 | Broken rule: 1 open-row activate, 2 access to closed bank, 3 tRP, 4 tRC, 5 tRCD, 6 tRAS, 7 unsupported command |
| bank_open | output | NUM_BANKS | Bit i high while bank i holds an open row |

## Verification
Each interval rule is tested with a command placed one cycle before its limit and then exactly at the limit. This separates an off-by-one in the counters from a correct bound, and the tRCD value is set to a non-multiple of the clock period so that floor rounding is exposed. Precharge is tried on a single open bank, on an idle bank and on all banks with one young row, which tells per-bank selection apart from all-bank selection and shows that a rejected all-bank precharge closes nothing. Automatic precharge is run once where tRAS dominates and once where the burst delay dominates. Commands with chip select high, and unsupported encodings, confirm that they are masked or flagged without touching bank state.

// File: rtl/dram_chk_pkg.sv
`timescale 1ns/1ps
package dram_chk_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_RD    = 3'd2,
    CMD_WR    = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_OTHER = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    V_NONE     = 3'd0,
    V_ACT_OPEN = 3'd1,
    V_NOT_OPEN = 3'd2,
    V_TRP      = 3'd3,
    V_TRC      = 3'd4,
    V_TRCD     = 3'd5,
    V_TRAS     = 3'd6,
    V_BADCMD   = 3'd7
  } viol_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_OPEN = 2'd1,
    B_APRE = 2'd2
  } bank_st_e;

  function automatic int ps_to_cyc(input int ps, input int clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dram_cmd_decode.sv
`timescale 1ns/1ps
module dram_cmd_decode
  import dram_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_OTHER;
      endcase
    end
  end

endmodule

// File: rtl/dram_bank_fsm.sv
`timescale 1ns/1ps
module dram_bank_fsm
  import dram_chk_pkg::*;
#(
  parameter int RCD_CYC   = 3,
  parameter int RP_CYC    = 3,
  parameter int RAS_CYC   = 9,
  parameter int RC_CYC    = 12,
  parameter int BURST_CYC = 2,
  parameter int CNT_W     = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  cmd_e  cmd,
  input  logic  sel,
  input  logic  pre_all,
  input  logic  ap_req,
  input  logic  accept,
  output viol_e err,
  output logic  row_open
);

  localparam int AP_W = $clog2(BURST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] RCD_L = CNT_W'(RCD_CYC);
  localparam logic [CNT_W-1:0] RP_L  = CNT_W'(RP_CYC);
  localparam logic [CNT_W-1:0] RAS_L = CNT_W'(RAS_CYC);
  localparam logic [CNT_W-1:0] RC_L  = CNT_W'(RC_CYC);
  localparam logic [AP_W-1:0]  BURST_L = AP_W'(BURST_CYC);
  localparam logic [AP_W-1:0]  AP_ONE  = AP_W'(1);

  bank_st_e         st;
  logic [CNT_W-1:0] act_cnt;
  logic [CNT_W-1:0] pre_cnt;
  logic [AP_W-1:0]  ap_wait;

  logic is_col;
  logic pre_hit;
  logic ap_fire;

  assign is_col   = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign pre_hit  = (cmd == CMD_PRE) && (sel || pre_all);
  assign ap_fire  = (st == B_APRE) && (ap_wait <= AP_ONE) && (act_cnt >= RAS_L);
  assign row_open = (st != B_IDLE);

  // rule evaluation for the command presented this cycle
  always_comb begin
    err = V_NONE;
    if (cmd == CMD_ACT && sel) begin
      if (st == B_OPEN)      err = V_ACT_OPEN;
      else if (st == B_APRE) err = V_TRP;
      else if (pre_cnt < RP_L) err = V_TRP;
      else if (act_cnt < RC_L) err = V_TRC;
    end else if (is_col && sel) begin
      if (st != B_OPEN)         err = V_NOT_OPEN;
      else if (act_cnt < RCD_L) err = V_TRCD;
    end else if (pre_hit) begin
      if (st == B_OPEN && act_cnt < RAS_L) err = V_TRAS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= B_IDLE;
      act_cnt <= CNT_MAX;
      pre_cnt <= CNT_MAX;
      ap_wait <= '0;
    end else begin
      if (act_cnt != CNT_MAX) act_cnt <= act_cnt + 1'b1;
      if (pre_cnt != CNT_MAX) pre_cnt <= pre_cnt + 1'b1;
      if (ap_wait != '0)      ap_wait <= ap_wait - 1'b1;

      if (ap_fire) begin
        st      <= B_IDLE;
        pre_cnt <= CNT_W'(1);
        ap_wait <= '0;
      end else if (accept) begin
        if (cmd == CMD_ACT && sel) begin
          st      <= B_OPEN;
          act_cnt <= CNT_W'(1);
        end else if (is_col && sel && ap_req) begin
          st      <= B_APRE;
          ap_wait <= BURST_L;
        end else if (pre_hit && st == B_OPEN) begin
          st      <= B_IDLE;
          pre_cnt <= CNT_W'(1);
        end
      end
    end
  end

  AST_ACT_OPENS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT && sel && accept) |=> (st == B_OPEN && act_cnt == CNT_W'(1))); // R3

  AST_COL_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && sel && accept) |-> (st == B_OPEN && act_cnt >= RCD_L)); // R4

  AST_AUTO_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == B_APRE && st == B_IDLE) |-> ($past(act_cnt) >= RAS_L)); // R10

  AST_CLOSE_STARTS_RP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) != B_IDLE && st == B_IDLE) |-> (pre_cnt == CNT_W'(1))); // R8

endmodule

// File: rtl/dram_viol_merge.sv
`timescale 1ns/1ps
module dram_viol_merge
  import dram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  cmd_e                   cmd,
  input  logic                   pre_all,
  input  logic [BA_W-1:0]        ba,
  input  logic [NUM_BANKS*3-1:0] bank_errs,
  output logic                   accept,
  output logic                   viol,
  output viol_e                  viol_code
);

  viol_e nxt;
  logic  any_err;

  always_comb begin
    any_err = 1'b0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_errs[i*3 +: 3] != 3'd0) any_err = 1'b1;
    end
    nxt = V_NONE;
    if (cmd == CMD_OTHER)      nxt = V_BADCMD;
    else if (pre_all)          nxt = any_err ? V_TRAS : V_NONE;
    else                       nxt = viol_e'(bank_errs[int'(ba)*3 +: 3]);
  end

  assign accept = (nxt == V_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol      <= 1'b0;
      viol_code <= V_NONE;
    end else begin
      viol      <= (nxt != V_NONE);
      viol_code <= nxt;
    end
  end

  AST_CODE_ONLY_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!viol) |-> (viol_code == V_NONE)); // R12

  AST_NOP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_NOP) |=> (!viol)); // R2

endmodule

// File: rtl/dram_bank_timing_checker.sv
`timescale 1ns/1ps
module dram_bank_timing_checker
  import dram_chk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CLK_PS    = 5000,
  parameter int T_RCD_PS  = 15000,
  parameter int T_RP_PS   = 15000,
  parameter int T_RAS_PS  = 45000,
  parameter int T_RC_PS   = 60000,
  parameter int BURST_CYC = 2,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic                 addr10,
  output logic                 viol,
  output logic [2:0]           viol_code,
  output logic [NUM_BANKS-1:0] bank_open
);

  localparam int RCD_CYC = ps_to_cyc(T_RCD_PS, CLK_PS);
  localparam int RP_CYC  = ps_to_cyc(T_RP_PS, CLK_PS);
  localparam int RAS_CYC = ps_to_cyc(T_RAS_PS, CLK_PS);
  localparam int RC_CYC  = ps_to_cyc(T_RC_PS, CLK_PS);
  localparam int MAX_CYC = max4(RCD_CYC, RP_CYC, RAS_CYC, RC_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  cmd_e                   cmd;
  logic                   pre_all;
  logic                   accept;
  logic [NUM_BANKS*3-1:0] bank_errs;
  viol_e                  code_q;

  dram_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd)
  );

  assign pre_all = (cmd == CMD_PRE) && addr10;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    viol_e err_g;
    dram_bank_fsm #(
      .RCD_CYC   (RCD_CYC),
      .RP_CYC    (RP_CYC),
      .RAS_CYC   (RAS_CYC),
      .RC_CYC    (RC_CYC),
      .BURST_CYC (BURST_CYC),
      .CNT_W     (CNT_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .sel      (ba == BA_W'(g)),
      .pre_all  (pre_all),
      .ap_req   (addr10),
      .accept   (accept),
      .err      (err_g),
      .row_open (bank_open[g])
    );
    assign bank_errs[g*3 +: 3] = err_g;
  end

  dram_viol_merge #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W)
  ) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .pre_all   (pre_all),
    .ba        (ba),
    .bank_errs (bank_errs),
    .accept    (accept),
    .viol      (viol),
    .viol_code (code_q)
  );

  assign viol_code = code_q;

  AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!viol)); // R2

  AST_REJECT_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && cmd == CMD_PRE) |=> (bank_open == $past(bank_open))); // R9

endmodule

// File: tb/dram_bank_timing_checker_tb.sv
`timescale 1ns/1ps
module dram_bank_timing_checker_tb;

  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic       addr10 = 1'b0;
  logic       viol;
  logic [2:0] viol_code;
  logic [NB-1:0] bank_open;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  // tRCD 12000 ps rounds up to 3; tRC raised so its rule can bind alone
  dram_bank_timing_checker #(
    .NUM_BANKS (NB),
    .CLK_PS    (5000),
    .T_RCD_PS  (12000),
    .T_RP_PS   (15000),
    .T_RAS_PS  (45000),
    .T_RC_PS   (70000),
    .BURST_CYC (2)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr10    (addr10),
    .viol      (viol),
    .viol_code (viol_code),
    .bank_open (bank_open)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  task automatic drive(input logic c, input logic r, input logic ca, input logic w,
                       input logic [1:0] b, input logic a, input int e, input string t);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; ba = b; addr10 = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic act(input logic [1:0] b, input int e, input string t);
    drive(1'b0, 1'b0, 1'b1, 1'b1, b, 1'b0, e, t);
  endtask
  task automatic rd(input logic [1:0] b, input logic ap, input int e, input string t);
    drive(1'b0, 1'b1, 1'b0, 1'b1, b, ap, e, t);
  endtask
  task automatic wr(input logic [1:0] b, input logic ap, input int e, input string t);
    drive(1'b0, 1'b1, 1'b0, 1'b0, b, ap, e, t);
  endtask
  task automatic pre(input logic [1:0] b, input logic all, input int e, input string t);
    drive(1'b0, 1'b0, 1'b1, 1'b0, b, all, e, t);
  endtask
  task automatic nop(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 0, "R12 idle");
  endtask

  // checks bank_open after the edge that samples the command just driven
  task automatic chk_open(input logic [NB-1:0] e, input string t);
    @(posedge clk);
    #2;
    nvec++;
    if (bank_open !== e) begin
      nfail++;
      $display("FAIL %s bank_open actual=%b expected=%b", t, bank_open, e);
    end
  endtask

  // monitor: one expected code per driven command, compared after its edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        nvec++;
        if (viol !== (e != 0) || viol_code !== 3'(e)) begin
          nfail++;
          $display("FAIL %s viol/code actual=%b/%0d expected=%b/%0d",
                   t, viol, viol_code, (e != 0), e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    nvec++;
    if (bank_open !== 4'b0000 || viol !== 1'b0 || viol_code !== 3'd0) begin
      nfail++;
      $display("FAIL R1 reset state actual=%b/%b/%0d expected=0000/0/0",
               bank_open, viol, viol_code);
    end
    rst_n = 1'b1;
    nop(2);

    // R11 unsupported encodings, R2 masked activate
    drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 7, "R11 refresh-like");
    drive(1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 1'b0, 7, "R11 strobes 110");
    nop(1);
    drive(1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 0, "R2 cs high act");
    chk_open(4'b0000, "R2 cs high no state");

    rd(2'd1, 1'b0, 2, "R4 read closed bank");

    // bank0 activate at e0
    act(2'd0, 0, "R3 act idle");
    chk_open(4'b0001, "R3 bank0 opens");
    act(2'd0, 1, "R3 act open bank");
    rd(2'd0, 1'b0, 5, "R5 R13 read at 2 cycles");
    wr(2'd0, 1'b0, 0, "R5 write at tRCD");
    pre(2'd0, 1'b0, 6, "R8 pre at 4 cycles");
    nop(3);
    pre(2'd0, 1'b0, 6, "R8 pre at 8 cycles");
    pre(2'd0, 1'b0, 0, "R8 pre at tRAS");
    chk_open(4'b0000, "R8 bank0 closed");
    act(2'd0, 3, "R6 act 1 after pre");
    act(2'd0, 3, "R6 act 2 after pre");
    act(2'd0, 4, "R7 act tRP ok tRC short");
    nop(1);
    act(2'd0, 0, "R7 act at tRC");

    // single and idle precharge
    act(2'd1, 0, "R3 act bank1");
    chk_open(4'b0011, "R3 two banks open");
    nop(8);
    pre(2'd0, 1'b0, 0, "R8 close bank0 only");
    chk_open(4'b0010, "R8 bank1 stays open");
    pre(2'd2, 1'b0, 0, "R8 pre idle bank");
    chk_open(4'b0010, "R8 idle pre no effect");

    // all-bank precharge
    act(2'd3, 0, "R9 act bank3");
    pre(2'd0, 1'b1, 6, "R9 pre-all young bank");
    chk_open(4'b1010, "R9 rejected pre-all closes none");
    nop(7);
    pre(2'd0, 1'b1, 0, "R9 pre-all ok");
    chk_open(4'b0000, "R9 all closed");

    // auto-precharge, tRAS dominates (act at f)
    act(2'd2, 0, "R10 act bank2");
    nop(2);
    rd(2'd2, 1'b1, 0, "R10 read with auto-pre");
    chk_open(4'b0100, "R10 row open while pending");
    rd(2'd2, 1'b0, 2, "R4 read while pending");
    act(2'd2, 3, "R6 act while pending");
    nop(2);
    nop(1);
    chk_open(4'b0100, "R10 still open before tRAS");
    nop(1);
    chk_open(4'b0000, "R10 closed at tRAS edge");
    nop(1);
    act(2'd2, 3, "R10 R6 act 2 after auto-pre");
    act(2'd2, 4, "R7 act after auto-pre tRC short");
    nop(1);
    act(2'd2, 0, "R7 act at tRC bank2");

    // auto-precharge, burst delay dominates (act at g)
    nop(9);
    wr(2'd2, 1'b1, 0, "R10 write with auto-pre");
    nop(1);
    chk_open(4'b0100, "R10 open during burst");
    nop(1);
    chk_open(4'b0000, "R10 closed after burst");

    nop(2);
    @(posedge clk);
    #3;
    finish_run();
  end

endmodule